// File: doc/BRIEF.md
# Nibble ALU with Skip Evaluation

This block is the 4-bit arithmetic and logic unit of a small tuning controller. Each cycle it takes a 5-bit operation code, a register operand, a memory operand, an immediate nibble and the current carry/borrow flag. It produces a nibble result, a write enable, a destination select (register or memory), the next value of the carry/borrow flag, and a skip request. The sequencer uses the skip request to annul the instruction that follows.

Operations come in two operand forms. In the register-memory form the operands are (register, memory) and the result goes back to the register. In the memory-immediate form the operands are (memory, immediate) and the result goes back to memory. Add and subtract come in plain, flag-in and skip-on-carry/borrow variants. Compares and mask tests only raise a skip request. The logic operations leave the flag alone. A right shift rotates the register through the flag.

All outputs are registered once, so the response to an operation appears one clock after it is presented. The data width is a parameter whose default is a nibble.

Top module: `nalu_core`

## Requirements
- R1: Every output is registered: an operation presented before a rising clock edge is reflected on the outputs after that edge. While rst_ni is low, res_o, wr_o, dst_mem_o, flag_o and skip_o are all 0.
- R2: For op[4:3]=00 (add group) the result is (a + b + (op[1] ? flag_i : 0)) mod 16. flag_o is the carry out and wr_o is 1.
- R3: The operand form follows op[2] in the add and subtract groups and op[0] in the logic group (1 = memory-immediate). Memory-immediate uses a=mem_i, b=imm_i and dst_mem_o=1. Register-memory uses a=reg_i, b=mem_i and dst_mem_o=0. Only a and b influence the result.
- R4: For op[4:3]=01 (subtract group) the result is (a - b - (op[1] ? flag_i : 0)) mod 16. flag_o is the borrow, which is 1 when a < b + borrow-in, and wr_o is 1.
- R5: In the add and subtract groups, skip_o equals the new carry (add) or borrow (subtract) when op[0]=1, and is 0 when op[0]=0. Outside the compare group (op[4:3]=10) no other operation raises skip_o.
- R6: Equality compares: 10000 skips when reg_i==mem_i, 10001 skips when mem_i==imm_i, and 10010 skips when mem_i!=imm_i.
- R7: Unsigned magnitude compares: 10011 skips when reg_i>=mem_i, 10100 skips when mem_i>=imm_i, and 10101 skips when mem_i<imm_i.
- R8: Mask tests: 10110 skips when every bit set in imm_i is 1 in mem_i, and 10111 skips when every such bit is 0 in mem_i. An all-zero mask makes both skip.
- R9: Every operation in the compare group (op[4:3]=10) gives wr_o=0, dst_mem_o=0 and res_o=0, and passes flag_i through unchanged to flag_o.
- R10: Logic group, op[4:3]=11 with op[2:1] 00=AND, 01=OR, 10=XOR: the result is the bitwise function of a and b, wr_o=1, flag_o=flag_i and skip_o=0.
- R11: Op 11110 (shift right) gives the result {flag_i, reg_i[3:1]} with flag_o=reg_i[0], wr_o=1, dst_mem_o=0 and skip_o=0.
- R12: Op 11111 is a no-operation: wr_o=0, res_o=0, dst_mem_o=0, skip_o=0 and flag_o=flag_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| reg_i | input | DATA_W | Register operand |
| mem_i | input | DATA_W | Memory operand |
| imm_i | input | DATA_W | Immediate operand or test mask |
| flag_i | input | 1 | Current carry/borrow flag |
| res_o | output | DATA_W | Result, zero when nothing is written |
| wr_o | output | 1 | Result write enable |
| dst_mem_o | output | 1 | Destination: 1 memory, 0 register |
| flag_o | output | 1 | Next carry/borrow flag |
| skip_o | output | 1 | Request to annul the next instruction |

## Verification
The bench sweeps every operation code against every pair of active operands and both flag values. The operand that a given form does not use is tied to a pattern that differs from the active ones. A wrong operand mux would therefore show up as a changed result, and a reversed borrow polarity would invert both the flag and the skip on every subtract and magnitude compare. The sweep also covers the boundary cases: 15+1 with and without carry-in, 0-0 with borrow-in, equal operands in the greater-or-equal and less-than compares, and the empty mask that must satisfy both mask tests. A design that let a compare or logic operation touch the flag, or let a non-skip variant raise a skip, miscompares on the first affected vector.

// File: rtl/nalu_pkg.sv
package nalu_pkg;
  localparam int OP_W = 5;

  localparam logic [1:0] G_ADD = 2'b00;
  localparam logic [1:0] G_SUB = 2'b01;
  localparam logic [1:0] G_CMP = 2'b10;
  localparam logic [1:0] G_LOG = 2'b11;

  typedef enum logic [2:0] {
    U_NONE, U_ARITH, U_CMP, U_LOGIC, U_SHIFT
  } unit_e;

  typedef enum logic [2:0] {
    C_NEVER, C_CARRY, C_EQ, C_NE, C_NOBRW, C_BRW, C_ALL1, C_ALL0
  } cond_e;

  typedef enum logic [1:0] {
    L_AND, L_OR, L_XOR
  } lfn_e;

  typedef struct packed {
    unit_e unit;
    logic  imm_form;
    logic  cin_en;
    logic  is_sub;
    cond_e cond;
    logic  wr;
    lfn_e  lfn;
  } ctrl_t;
endpackage

// File: rtl/nalu_decode.sv
module nalu_decode
  import nalu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  logic [1:0] grp;
  logic [2:0] sub;

  assign grp = op_i[4:3];
  assign sub = op_i[2:0];

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.unit     = U_NONE;
    ctrl_o.cond     = C_NEVER;
    ctrl_o.lfn      = L_AND;
    unique case (grp)
      G_ADD, G_SUB: begin
        ctrl_o.unit     = U_ARITH;
        ctrl_o.is_sub   = (grp == G_SUB);
        ctrl_o.imm_form = sub[2];
        ctrl_o.cin_en   = sub[1];
        ctrl_o.cond     = sub[0] ? C_CARRY : C_NEVER;
        ctrl_o.wr       = 1'b1;
      end
      G_CMP: begin
        ctrl_o.unit   = U_CMP;
        ctrl_o.is_sub = 1'b1;
        unique case (sub)
          3'd0: begin ctrl_o.imm_form = 1'b0; ctrl_o.cond = C_EQ;    end
          3'd1: begin ctrl_o.imm_form = 1'b1; ctrl_o.cond = C_EQ;    end
          3'd2: begin ctrl_o.imm_form = 1'b1; ctrl_o.cond = C_NE;    end
          3'd3: begin ctrl_o.imm_form = 1'b0; ctrl_o.cond = C_NOBRW; end
          3'd4: begin ctrl_o.imm_form = 1'b1; ctrl_o.cond = C_NOBRW; end
          3'd5: begin ctrl_o.imm_form = 1'b1; ctrl_o.cond = C_BRW;   end
          3'd6: begin ctrl_o.imm_form = 1'b1; ctrl_o.cond = C_ALL1;  end
          default: begin ctrl_o.imm_form = 1'b1; ctrl_o.cond = C_ALL0; end
        endcase
      end
      default: begin
        if (sub[2:1] == 2'b11) begin
          if (!sub[0]) begin
            ctrl_o.unit = U_SHIFT;
            ctrl_o.wr   = 1'b1;
          end
        end else begin
          ctrl_o.unit     = U_LOGIC;
          ctrl_o.imm_form = sub[0];
          ctrl_o.wr       = 1'b1;
          unique case (sub[2:1])
            2'b00:   ctrl_o.lfn = L_AND;
            2'b01:   ctrl_o.lfn = L_OR;
            default: ctrl_o.lfn = L_XOR;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/nalu_arith.sv
// Single shared adder: add, subtract and compare all run through it.
module nalu_arith #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              is_sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,  // carry for add, borrow for subtract
  output logic              zero_o
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [SUM_W-1:0]  sum;

  assign b_eff  = is_sub_i ? ~b_i : b_i;
  assign c_eff  = is_sub_i ? ~cin_i : cin_i;
  assign sum    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
  assign res_o  = sum[DATA_W-1:0];
  assign cout_o = is_sub_i ? ~sum[DATA_W] : sum[DATA_W];
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/nalu_logic.sv
module nalu_logic
  import nalu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lfn_e              lfn_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] lres_o,
  output logic [DATA_W-1:0] shres_o,
  output logic              shflag_o,
  output logic              all1_o,
  output logic              all0_o
);
  logic [DATA_W-1:0] masked;

  always_comb begin
    unique case (lfn_i)
      L_OR:    lres_o = a_i | b_i;
      L_XOR:   lres_o = a_i ^ b_i;
      default: lres_o = a_i & b_i;
    endcase
  end

  // rotate right through the flag
  assign shres_o  = {flag_i, a_i[DATA_W-1:1]};
  assign shflag_o = a_i[0];

  assign masked = a_i & b_i;
  assign all1_o = (masked == b_i);
  assign all0_o = (masked == '0);
endmodule

// File: rtl/nalu_skip.sv
module nalu_skip
  import nalu_pkg::*;
(
  input  cond_e cond_i,
  input  logic  cout_i,
  input  logic  zero_i,
  input  logic  all1_i,
  input  logic  all0_i,
  output logic  skip_o
);
  always_comb begin
    unique case (cond_i)
      C_CARRY: skip_o = cout_i;
      C_EQ:    skip_o = zero_i;
      C_NE:    skip_o = ~zero_i;
      C_NOBRW: skip_o = ~cout_i;
      C_BRW:   skip_o = cout_i;
      C_ALL1:  skip_o = all1_i;
      C_ALL0:  skip_o = all0_i;
      default: skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nalu_core.sv
module nalu_core
  import nalu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic              dst_mem_o,
  output logic              flag_o,
  output logic              skip_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W-1:0] ares, lres, shres;
  logic              cout, zero, shflag, all1, all0, skip_d;
  logic [DATA_W-1:0] res_d;
  logic              flag_d;

  nalu_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  assign opa = ctrl.imm_form ? mem_i : reg_i;
  assign opb = ctrl.imm_form ? imm_i : mem_i;

  nalu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i     (opa),
    .b_i     (opb),
    .cin_i   (ctrl.cin_en & flag_i),
    .is_sub_i(ctrl.is_sub),
    .res_o   (ares),
    .cout_o  (cout),
    .zero_o  (zero)
  );

  nalu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i     (opa),
    .b_i     (opb),
    .lfn_i   (ctrl.lfn),
    .flag_i  (flag_i),
    .lres_o  (lres),
    .shres_o (shres),
    .shflag_o(shflag),
    .all1_o  (all1),
    .all0_o  (all0)
  );

  nalu_skip u_skip (
    .cond_i(ctrl.cond),
    .cout_i(cout),
    .zero_i(zero),
    .all1_i(all1),
    .all0_i(all0),
    .skip_o(skip_d)
  );

  always_comb begin
    res_d  = '0;
    flag_d = flag_i;
    unique case (ctrl.unit)
      U_ARITH: begin res_d = ares;  flag_d = cout;   end
      U_LOGIC: res_d = lres;
      U_SHIFT: begin res_d = shres; flag_d = shflag; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      wr_o      <= 1'b0;
      dst_mem_o <= 1'b0;
      flag_o    <= 1'b0;
      skip_o    <= 1'b0;
    end else begin
      res_o     <= res_d;
      wr_o      <= ctrl.wr;
      dst_mem_o <= ctrl.wr & ctrl.imm_form;
      flag_o    <= flag_d;
      skip_o    <= skip_d;
    end
  end
endmodule

// File: rtl/nalu_chk.sv
module nalu_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        op_i,
  input logic              reg_lsb_i,
  input logic [DATA_W-1:0] imm_i,
  input logic              flag_i,
  input logic              res_msb_i,
  input logic              wr_i,
  input logic              flag_o_i,
  input logic              skip_i
);
  a_r9_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[4:3] == 2'b10) |=> (!wr_i && flag_o_i == $past(flag_i)));

  a_r5_no_stray_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[4:3] != 2'b10 && !(!op_i[4] && op_i[0])) |=> !skip_i);

  a_r10_logic_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[4:3] == 2'b11 && op_i[2:1] != 2'b11) |=> (wr_i && flag_o_i == $past(flag_i)));

  a_r11_shift_rotates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'b11110) |=> (flag_o_i == $past(reg_lsb_i) && res_msb_i == $past(flag_i)));

  a_r12_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'b11111) |=> (!wr_i && !skip_i && flag_o_i == $past(flag_i)));

  a_r8_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[4:1] == 4'b1011 && imm_i == '0) |=> skip_i);
endmodule

bind nalu_core nalu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .reg_lsb_i(reg_i[0]),
  .imm_i    (imm_i),
  .flag_i   (flag_i),
  .res_msb_i(res_o[DATA_W-1]),
  .wr_i     (wr_o),
  .flag_o_i (flag_o),
  .skip_i   (skip_o)
);

// File: tb/nalu_core_bench.sv
module nalu_core_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [3:0] reg_i = '0, mem_i = '0, imm_i = '0;
  logic       flag_i = 1'b0;
  logic [3:0] res_o;
  logic       wr_o, dst_mem_o, flag_o, skip_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  nalu_core u_nalu_core (
    .clk_i, .rst_ni, .op_i, .reg_i, .mem_i, .imm_i, .flag_i,
    .res_o, .wr_o, .dst_mem_o, .flag_o, .skip_o
  );

  function automatic bit uses_imm(logic [4:0] op);
    case (op[4:3])
      2'b00, 2'b01: return op[2];
      2'b10:        return !(op[2:0] == 3'd0 || op[2:0] == 3'd3);
      default:      return (op[2:1] != 2'b11) && op[0];
    endcase
  endfunction

  // {res, wr, dst, flag, skip}
  function automatic logic [7:0] model(logic [4:0] op, logic [3:0] r, logic [3:0] m,
                                       logic [3:0] im, logic f);
    int a, b, s, ci;
    logic [3:0] res; logic wr, dst, fl, sk;
    a  = uses_imm(op) ? int'(m) : int'(r);
    b  = uses_imm(op) ? int'(im) : int'(m);
    ci = (op[1] && f) ? 1 : 0;
    res = 0; wr = 0; dst = 0; fl = f; sk = 0;
    case (op[4:3])
      2'b00: begin
        s = a + b + ci; res = 4'(s); fl = (s > 15); wr = 1; dst = op[2]; sk = op[0] & fl;
      end
      2'b01: begin
        s = a - b - ci; res = 4'(s); fl = (s < 0); wr = 1; dst = op[2]; sk = op[0] & fl;
      end
      2'b10: case (op[2:0])
        3'd0, 3'd1: sk = (a == b);
        3'd2:       sk = (a != b);
        3'd3, 3'd4: sk = (a >= b);
        3'd5:       sk = (a < b);
        3'd6:       sk = ((a & b) == b);
        default:    sk = ((a & b) == 0);
      endcase
      default: case (op[2:1])
        2'b00: begin res = 4'(a & b); wr = 1; dst = op[0]; end
        2'b01: begin res = 4'(a | b); wr = 1; dst = op[0]; end
        2'b10: begin res = 4'(a ^ b); wr = 1; dst = op[0]; end
        default: if (!op[0]) begin res = {f, r[3:1]}; fl = r[0]; wr = 1; end
      endcase
    endcase
    return {res, wr, dst, fl, sk};
  endfunction

  function automatic string tag_of(logic [4:0] op, logic [7:0] g, logic [7:0] e);
    if (g[2] !== e[2]) return "R3";
    case (op[4:3])
      2'b00: return (g[0] !== e[0]) ? "R5" : "R2";
      2'b01: return (g[0] !== e[0]) ? "R5" : "R4";
      2'b10: begin
        if (g[7:1] !== e[7:1]) return "R9";
        if (op[2:0] < 3) return "R6";
        if (op[2:0] < 6) return "R7";
        return "R8";
      end
      default: begin
        if (op[2:1] != 2'b11) return "R10";
        return op[0] ? "R12" : "R11";
      end
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b reg=%h mem=%h imm=%h flag=%b got=%h exp=%h",
               tag, op_i, reg_i, mem_i, imm_i, flag_i, got, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {res_o, wr_o, dst_mem_o, flag_o, skip_o};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state, with inputs asking for a write
    op_i = 5'b00000; reg_i = 4'h7; mem_i = 4'h9; flag_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", outs(), 8'h00);
    rst_ni = 1'b1;

    for (int op = 0; op < 32; op++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int f = 0; f < 2; f++) begin
            logic [4:0] o;
            o = 5'(op);
            @(negedge clk_i);
            op_i = o; flag_i = f[0];
            if (uses_imm(o)) begin
              mem_i = 4'(x); imm_i = 4'(y); reg_i = 4'(x) ^ 4'h5;
            end else begin
              reg_i = 4'(x); mem_i = 4'(y); imm_i = 4'(y) ^ 4'ha;
            end
            @(negedge clk_i);
            begin
              logic [7:0] e, g;
              e = model(o, reg_i, mem_i, imm_i, flag_i);
              g = outs();
              check(tag_of(o, g, e), g, e);
            end
          end

    // R1: asynchronous reset clears a pending write
    @(negedge clk_i);
    op_i = 5'b00011; reg_i = 4'hf; mem_i = 4'h1; flag_i = 1'b1;
    @(negedge clk_i);
    check("R2", outs(), model(op_i, reg_i, mem_i, imm_i, flag_i));
    #1 rst_ni = 1'b0;
    #0.5 check("R1", outs(), 8'h00);
    @(negedge clk_i);
    check("R1", outs(), 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", outs(), model(op_i, reg_i, mem_i, imm_i, flag_i));
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      finish_run();
    end
  end
endmodule